// File: doc/BRIEF.md
# Byte-Select SRAM Strobe Controller

This block turns single host requests into strobe sequences for a 16-bit asynchronous SRAM that has separate upper-byte and lower-byte select pins. The host presents an address, a read/write flag, two byte enables and write data. The controller then runs one setup cycle, a programmable number of strobe cycles and, in one mode, a programmable number of hold cycles. It drives chip select, a read strobe, a read/write pin, two byte selects and the write-data output enable. At the end it pulses a done flag, with read data returned in lanes masked to the enabled bytes.

A mode bit decides which pin times a write. In byte-strobe mode (mode 0), the read/write pin stays low for the whole write and the byte selects pulse as per-byte write strobes. Reads pulse the byte selects as well. In pin-strobe mode (mode 1), the byte selects stay low across the whole access and the read/write pin pulses as the write strobe. A hold count then keeps address and data on the bus after that pin is released.

Top module: `bsram_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, chip select, read strobe, read/write pin and both byte selects are high, the data output enable is low and done is low.
- R2: An accepted request with a nonzero byte enable gives one setup cycle, with chip select low and no strobe, then W+1 strobe cycles, where W is the latched wait field. Done is high for the single cycle after the last access cycle, and chip select is high in that cycle.
- R3: In mode 0, a write holds the read/write pin low through setup and strobe cycles. Each byte select is low only in strobe cycles and only if enabled (byte-enable bit 1 drives the upper select, bit 0 the lower). The hold field has no effect.
- R4: In mode 0, a read drives the read strobe low in the strobe cycles. The enabled byte selects are low in the same cycles, and the read/write pin stays high.
- R5: In mode 1, a write drives the read/write pin low only in the strobe cycles. The enabled byte selects are low for every cycle chip select is low. After the strobe, H hold cycles follow (H = latched 2-bit hold field), with chip select low and the read/write pin high.
- R6: In mode 1, a read drives the read strobe low in the strobe cycles and the enabled byte selects low for the whole access. No hold cycles are added.
- R7: For a write, the data output enable is high and the data output equals the request's write data in every cycle chip select is low. The enable is never high during a read or when idle.
- R8: Read data is the bus value in the last strobe cycle. Lanes whose byte enable is 0 read as zero (bits 15:8 follow byte-enable bit 1, bits 7:0 follow bit 0).
- R9: A request with byte enable 00 raises done in the next cycle and never lowers chip select.
- R10: A request that arrives while an access is in progress is ignored. Address, data, mode, wait and hold are latched when a request is accepted, and the bus address stays stable for the whole access.
- R11: The read strobe and the read/write pin are never low together, and no strobe is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| cfg_mode | input | 1 | 0 = byte selects strobe writes, 1 = read/write pin strobes writes |
| cfg_wait | input | WAIT_W | Extra strobe cycles |
| cfg_hold | input | 2 | Hold cycles after a mode-1 write strobe |
| mem_addr | output | ADDR_W | SRAM address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Read/write pin, low = write |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Write data output enable |
| mem_dq_in | input | 16 | Read data from the bus |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Masked read data |

## Verification
The hardest points to reach from the ports are the exact sampling cycle of read data and the claim that mid-access inputs are ignored. The bench changes the bus value on every strobe cycle, so only a capture in the last strobe cycle gives the expected word. During every access it also raises a second request and alters address, mode, wait and hold. The latched timing and a stable bus address then show that the second request and the new settings were ignored. Each table vector mixes mode, direction, byte enables, wait and hold so that pin low-times can be counted against the per-mode formulas.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic oe;
    } pins_t;

endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic [DATA_W-1:0] bus_rdata,
    output phase_t            phase,
    output logic              lat_mode,
    output logic              lat_wr,
    output logic [1:0]        lat_be,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    localparam int CNT_W  = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;
    localparam int LANE_W = DATA_W / 2;

    typedef struct packed {
        phase_t            phase;
        logic [CNT_W-1:0]  cnt;
        logic              mode;
        logic              wr;
        logic [1:0]        be;
        logic [HOLD_W-1:0] hold;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t st_d, st_q;
    logic [DATA_W-1:0] masked_d;

    always_comb begin
        masked_d[DATA_W-1:LANE_W] = st_q.be[1] ? bus_rdata[DATA_W-1:LANE_W] : '0;
        masked_d[LANE_W-1:0]      = st_q.be[0] ? bus_rdata[LANE_W-1:0] : '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.mode  = cfg_mode;
                    st_d.wr    = req_wr;
                    st_d.be    = req_be;
                    st_d.hold  = cfg_hold;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cnt   = CNT_W'(cfg_wait);
                    if (req_be == 2'b00) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                st_d.phase = PH_STROBE;
            end
            PH_STROBE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    if (!st_q.wr) begin
                        st_d.rdata = masked_d;
                    end
                    if (st_q.mode && st_q.wr && (st_q.hold != '0)) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = CNT_W'(st_q.hold - HOLD_W'(1));
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign lat_mode  = st_q.mode;
    assign lat_wr    = st_q.wr;
    assign lat_be    = st_q.be;
    assign lat_addr  = st_q.addr;
    assign lat_wdata = st_q.wdata;
    assign done      = st_q.done;
    assign rdata     = st_q.rdata;

endmodule

// File: rtl/bsram_pins.sv
module bsram_pins
    import bsram_pkg::*;
(
    input  phase_t     phase,
    input  logic       mode,
    input  logic       wr,
    input  logic [1:0] be,
    output pins_t      pins
);

    logic active;
    logic strobe;
    logic sel;

    always_comb begin
        active = (phase != PH_IDLE);
        strobe = (phase == PH_STROBE);
        // mode 1 keeps byte selects on for the whole access; mode 0 pulses them
        sel    = mode ? active : strobe;

        pins.cs_n = !active;
        pins.rd_n = !(strobe && !wr);
        if (mode) begin
            pins.we_n = !(strobe && wr);
        end else begin
            pins.we_n = !(wr && ((phase == PH_SETUP) || strobe));
        end
        pins.ub_n = !(sel && be[1]);
        pins.lb_n = !(sel && be[0]);
        pins.oe   = active && wr;
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    phase_t            phase;
    logic              lat_mode;
    logic              lat_wr;
    logic [1:0]        lat_be;
    pins_t             pins;

    bsram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_W (WAIT_W),
        .HOLD_W (HOLD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .req_be    (req_be),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cfg_mode  (cfg_mode),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .bus_rdata (mem_dq_in),
        .phase     (phase),
        .lat_mode  (lat_mode),
        .lat_wr    (lat_wr),
        .lat_be    (lat_be),
        .lat_addr  (mem_addr),
        .lat_wdata (mem_dq_out),
        .done      (rsp_done),
        .rdata     (rsp_rdata)
    );

    bsram_pins u_pins (
        .phase (phase),
        .mode  (lat_mode),
        .wr    (lat_wr),
        .be    (lat_be),
        .pins  (pins)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_rd_n  = pins.rd_n;
    assign mem_we_n  = pins.we_n;
    assign mem_ub_n  = pins.ub_n;
    assign mem_lb_n  = pins.lb_n;
    assign mem_dq_oe = pins.oe;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              we_n,
    input logic              ub_n,
    input logic              lb_n,
    input logic              dq_oe,
    input logic              done,
    input logic [ADDR_W-1:0] addr
);

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !we_n || !ub_n || !lb_n) |-> !cs_n); // R11

    AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n)); // R11

    AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (rd_n && !cs_n)); // R7

    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R10

endmodule

bind bsram_ctrl bsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (mem_cs_n),
    .rd_n  (mem_rd_n),
    .we_n  (mem_we_n),
    .ub_n  (mem_ub_n),
    .lb_n  (mem_lb_n),
    .dq_oe (mem_dq_oe),
    .done  (rsp_done),
    .addr  (mem_addr)
);

// File: tb/bsram_ctrl_bench.sv
`timescale 1ns/1ps
module bsram_ctrl_bench;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_wr = 1'b0;
    logic [1:0]        req_be = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic              cfg_mode = 1'b0;
    logic [3:0]        cfg_wait = '0;
    logic [1:0]        cfg_hold = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_cs_n, mem_rd_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0]       mem_dq_out;
    logic              mem_dq_oe;
    logic [15:0]       mem_dq_in = '0;
    logic              rsp_done;
    logic [15:0]       rsp_rdata;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    bsram_ctrl u_bsram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_mode(cfg_mode), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        mode;
        logic        wr;
        logic [1:0]  be;
        logic [3:0]  wt;
        logic [1:0]  hold;
        logic [15:0] rbase;
        logic [7:0]  exp_lat;
        logic [15:0] exp_rdata;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 2'b11, 4'd0, 2'd3, 16'h0000, 8'd3, 16'h0000},
        '{1'b0, 1'b1, 2'b10, 4'd2, 2'd0, 16'h0000, 8'd5, 16'h0000},
        '{1'b0, 1'b0, 2'b11, 4'd1, 2'd2, 16'h1200, 8'd4, 16'h1201},
        '{1'b0, 1'b0, 2'b01, 4'd3, 2'd0, 16'hA5F0, 8'd6, 16'h00F3},
        '{1'b1, 1'b1, 2'b11, 4'd1, 2'd2, 16'h0000, 8'd6, 16'h0000},
        '{1'b1, 1'b1, 2'b01, 4'd0, 2'd0, 16'h0000, 8'd3, 16'h0000},
        '{1'b1, 1'b1, 2'b10, 4'd2, 2'd3, 16'h0000, 8'd8, 16'h0000},
        '{1'b1, 1'b0, 2'b10, 4'd0, 2'd3, 16'h7C3E, 8'd3, 16'h7C00},
        '{1'b1, 1'b0, 2'b11, 4'd2, 2'd1, 16'h0101, 8'd5, 16'h0103}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-access observations
    int lat, n_cs, n_rd, n_we, n_ub, n_lb, n_oe, n_dbad, n_abad, n_csdone;

    task automatic run_access(input logic mode, input logic wr, input logic [1:0] be,
                              input logic [3:0] wt, input logic [1:0] hold,
                              input logic [ADDR_W-1:0] addr, input logic [15:0] wdata,
                              input logic [15:0] rbase);
        int sidx = 0;
        lat = 0; n_cs = 0; n_rd = 0; n_we = 0; n_ub = 0; n_lb = 0;
        n_oe = 0; n_dbad = 0; n_abad = 0; n_csdone = 0;
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_be = be; req_addr = addr;
        req_wdata = wdata; cfg_mode = mode; cfg_wait = wt; cfg_hold = hold;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            if (k == 1) begin
                // R10: disturb every latched input mid-access
                cfg_mode = ~mode; cfg_wait = wt + 4'd5; cfg_hold = hold + 2'd1;
                req_addr = ~addr; req_wdata = ~wdata; req_wr = ~wr; req_be = ~be;
            end
            req_valid = (k == 2);
            if (rsp_done) begin
                lat = k;
                if (!mem_cs_n) n_csdone++;
                break;
            end
            if (!mem_cs_n) n_cs++;
            if (!mem_rd_n) n_rd++;
            if (!mem_we_n) n_we++;
            if (!mem_ub_n) n_ub++;
            if (!mem_lb_n) n_lb++;
            if (mem_dq_oe) begin
                n_oe++;
                if (mem_dq_out != wdata) n_dbad++;
            end
            if (!mem_cs_n && mem_addr != addr) n_abad++;
            if (!mem_rd_n) begin
                mem_dq_in = rbase + 16'(sidx);
                sidx++;
            end else begin
                mem_dq_in = 16'hDEAD;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_rd_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_done,
              "R1 pins during reset", {mem_cs_n, mem_rd_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rsp_done},
              7'b1111100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_rd_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_done,
              "R1 pins idle after reset", {mem_cs_n, mem_rd_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rsp_done},
              7'b1111100);

        for (int v = 0; v < NVEC; v++) begin
            automatic vec_t t = VECS[v];
            automatic logic [ADDR_W-1:0] a = ADDR_W'(20'h1_2340 + v * 20'h111);
            automatic logic [15:0] wd = 16'h3C00 ^ 16'(v * 16'h0B57);
            automatic int s = int'(t.wt) + 1;
            automatic int hx = (t.mode && t.wr) ? int'(t.hold) : 0;
            automatic int acc = 1 + s + hx;
            automatic int sel = t.mode ? acc : s;
            automatic int e_we = t.wr ? (t.mode ? s : 1 + s) : 0;
            run_access(t.mode, t.wr, t.be, t.wt, t.hold, a, wd, t.rbase);
            check(lat == int'(t.exp_lat), $sformatf("R2 done latency v%0d", v), lat, int'(t.exp_lat));
            check(n_cs == acc && n_csdone == 0, $sformatf("R2 cs low cycles v%0d", v), n_cs, acc);
            if (t.mode == 1'b0 && t.wr) begin
                check(n_we == e_we && n_rd == 0, $sformatf("R3 rw pin low v%0d", v), n_we, e_we);
                check(n_ub == (t.be[1] ? sel : 0) && n_lb == (t.be[0] ? sel : 0),
                      $sformatf("R3 byte strobes v%0d", v), n_ub * 100 + n_lb,
                      (t.be[1] ? sel : 0) * 100 + (t.be[0] ? sel : 0));
            end else if (t.mode == 1'b0) begin
                check(n_rd == s && n_we == 0, $sformatf("R4 read strobe v%0d", v), n_rd, s);
                check(n_ub == (t.be[1] ? sel : 0) && n_lb == (t.be[0] ? sel : 0),
                      $sformatf("R4 byte strobes v%0d", v), n_ub * 100 + n_lb,
                      (t.be[1] ? sel : 0) * 100 + (t.be[0] ? sel : 0));
            end else if (t.wr) begin
                check(n_we == e_we && n_rd == 0, $sformatf("R5 rw pin low v%0d", v), n_we, e_we);
                check(n_ub == (t.be[1] ? sel : 0) && n_lb == (t.be[0] ? sel : 0),
                      $sformatf("R5 byte selects held v%0d", v), n_ub * 100 + n_lb,
                      (t.be[1] ? sel : 0) * 100 + (t.be[0] ? sel : 0));
            end else begin
                check(n_rd == s && n_we == 0, $sformatf("R6 read strobe v%0d", v), n_rd, s);
                check(n_ub == (t.be[1] ? sel : 0) && n_lb == (t.be[0] ? sel : 0),
                      $sformatf("R6 byte selects held v%0d", v), n_ub * 100 + n_lb,
                      (t.be[1] ? sel : 0) * 100 + (t.be[0] ? sel : 0));
            end
            check(n_oe == (t.wr ? acc : 0) && n_dbad == 0, $sformatf("R7 data drive v%0d", v),
                  n_oe * 100 + n_dbad, (t.wr ? acc : 0) * 100);
            if (!t.wr) begin
                check(rsp_rdata == t.exp_rdata, $sformatf("R8 read data v%0d", v),
                      int'(rsp_rdata), int'(t.exp_rdata));
            end
            check(n_abad == 0, $sformatf("R10 address stable v%0d", v), n_abad, 0);
            check(mem_cs_n && !rsp_done, $sformatf("R10 no second access v%0d", v),
                  {mem_cs_n, rsp_done}, 2'b10);
        end

        // R9: empty byte enable
        run_access(1'b1, 1'b1, 2'b00, 4'd3, 2'd3, 20'h0_0ABC, 16'h5555, 16'h0);
        check(lat == 1, "R9 immediate done", lat, 1);
        check(n_cs == 0 && n_oe == 0, "R9 no bus cycle", n_cs * 100 + n_oe, 0);

        // R8: read data kept after a write and lane mask of upper-only read
        run_access(1'b0, 1'b0, 2'b10, 4'd0, 2'd0, 20'h0_0F0F, 16'h0, 16'hBEEF);
        check(rsp_rdata == 16'hBE00, "R8 upper lane only", int'(rsp_rdata), 16'hBE00);

        // R11: rd and rw pin never both low across a mixed pair
        run_access(1'b0, 1'b1, 2'b01, 4'd1, 2'd1, 20'h0_1111, 16'h00A5, 16'h0);
        check(n_rd == 0 && n_we == 3, "R11 write has no read strobe", n_rd * 100 + n_we, 3);

        finish_run();
    end

endmodule